// File: doc/BRIEF.md
# Serial-In Latched LED Channel Driver Core

This block is the digital core of a multi-channel constant-current LED sink driver. A host clocks serial data into a shift register one bit per rising clock edge. A latch-enable level copies the shift register into a bank of data latches. The latched bits then decide which of the channel current sinks are on. The bit that leaves the far end of the shift register drives a serial output, so several drivers can be daisy-chained on one data line.

Two conditions turn every channel off whatever the latches hold. The first is an active-low output enable, which acts asynchronously and is used for brightness control by pulse width. The second is an internal overtemperature flag. It is derived from a digital temperature code, with separate set and release thresholds giving hysteresis. Normal operation resumes by itself once the temperature has fallen far enough. The analog current regulation is not modelled: each channel is a single on/off enable bit.

Top module: `led_sink_core`

## Requirements
- R1: On each rising edge of `clk` the shift register moves one place toward the high end and takes `ser_in` into bit 0. After NCH edges, the bit shifted first sits at position NCH-1 and the newest bit at position 0. Position i feeds channel i.
- R2: `ser_out` equals the bit taken from `ser_in` NCH rising edges earlier. It changes only on a rising edge of `clk`.
- R3: While `latch_en` is high, the latches are transparent. The latched value follows the shift register with no clock edge needed.
- R4: While `latch_en` is low, the latches keep their value, even as the shift register keeps shifting.
- R5: While `out_en_n` is high, `chan_on` is all zeros, with no clock edge needed.
- R6: While `out_en_n` is low and the thermal flag is clear, `chan_on[i]` is 1 exactly when latched bit i is 1.
- R7: The thermal flag sets on the first rising edge at which `temp_code` >= SET_T (default 170). From that edge on, `chan_on` is all zeros. A code of SET_T-1 does not set it.
- R8: Once set, the thermal flag stays set while `temp_code` > CLR_T (default 155). It clears on the first rising edge at which `temp_code` <= CLR_T, and the latched data then drives the channels again.
- R9: While `rst_n` is low, the shift register, the latches and the thermal flag are cleared. `ser_out` and `chan_on` then read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| latch_en | input | 1 | Level-sensitive latch enable, high = transparent |
| out_en_n | input | 1 | Active-low output enable, high blanks all channels |
| temp_code | input | TEMP_W (8) | Digital die temperature code |
| ser_out | output | 1 | Serial data output for chaining |
| chan_on | output | NCH (16) | Per-channel sink enable, 1 = on |

## Verification
A corrupted shift-register bit shows up in two places. It reaches `ser_out` after at most NCH edges. It also reaches the channel that bit maps to, at the next latch pulse. A latch that leaks while its enable is low changes `chan_on` within one clock edge, with no latch pulse. A thermal flag holding the wrong state blanks the channels, or fails to blank them, one edge after the temperature code moves. The bench therefore compares `ser_out` with its own serial model on every cycle, and compares `chan_on` after every latch pulse and every threshold crossing.

// File: rtl/led_pkg.sv
package led_pkg;

  typedef enum logic {
    TH_COOL = 1'b0,
    TH_HOT  = 1'b1
  } therm_e;

  // Hysteresis decision: enter HOT at or above the set level,
  // leave it only at or below the release level.
  function automatic therm_e therm_next(therm_e cur, logic [31:0] t,
                                        logic [31:0] set_t, logic [31:0] clr_t);
    if (cur == TH_COOL) return (t >= set_t) ? TH_HOT : TH_COOL;
    else                return (t <= clr_t) ? TH_COOL : TH_HOT;
  endfunction

  // Any blanking source forces a channel off.
  function automatic logic chan_gate(logic bit_q, logic oe_n, logic hot);
    return bit_q & ~oe_n & ~hot;
  endfunction

endpackage

// File: rtl/led_shift_reg.sv
module led_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/led_data_latch.sv
module led_data_latch #(
  parameter int W = 16
) (
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)  q = '0;
    else if (le) q = d;
  end
endmodule

// File: rtl/led_thermal_mon.sv
module led_thermal_mon
  import led_pkg::*;
#(
  parameter int          TW    = 8,
  parameter int unsigned SET_T = 170,
  parameter int unsigned CLR_T = 155
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] temp,
  output logic          hot
);
  therm_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TH_COOL;
    else        st_q <= therm_next(st_q, 32'(temp), 32'(SET_T), 32'(CLR_T));
  end

  assign hot = (st_q == TH_HOT);
endmodule

// File: rtl/led_sink_core.sv
module led_sink_core
  import led_pkg::*;
#(
  parameter int          NCH    = 16,
  parameter int          TEMP_W = 8,
  parameter int unsigned SET_T  = 170,
  parameter int unsigned CLR_T  = 155
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              latch_en,
  input  logic              out_en_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              ser_out,
  output logic [NCH-1:0]    chan_on
);
  localparam int MSB = NCH - 1;

  // Named internal events, visible to the bound checker.
  logic [NCH-1:0] shift_q;
  logic [NCH-1:0] latch_q;
  logic           hot;

  led_shift_reg #(.W(NCH)) u_shift (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ser_in),
    .q    (shift_q)
  );

  led_data_latch #(.W(NCH)) u_latch (
    .rst_n(rst_n),
    .le   (latch_en),
    .d    (shift_q),
    .q    (latch_q)
  );

  led_thermal_mon #(.TW(TEMP_W), .SET_T(SET_T), .CLR_T(CLR_T)) u_therm (
    .clk  (clk),
    .rst_n(rst_n),
    .temp (temp_code),
    .hot  (hot)
  );

  assign ser_out = shift_q[MSB];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign chan_on[i] = chan_gate(latch_q[i], out_en_n, hot);
  end
endmodule

// File: rtl/led_sink_core_chk.sv
module led_sink_core_chk #(
  parameter int          NCH    = 16,
  parameter int          TEMP_W = 8,
  parameter int unsigned SET_T  = 170,
  parameter int unsigned CLR_T  = 155
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_in,
  input logic              out_en_n,
  input logic [TEMP_W-1:0] temp_code,
  input logic [NCH-1:0]    shift_q,
  input logic [NCH-1:0]    latch_q,
  input logic              hot,
  input logic [NCH-1:0]    chan_on
);
  // R1: newest bit lands in position 0
  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> shift_q[0] == $past(ser_in));

  // R2: each bit moves one place per edge toward ser_out
  a_r2_chain: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> shift_q[NCH-1:1] == $past(shift_q[NCH-2:0]));

  // R5: output enable high blanks everything
  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> chan_on == '0);

  // R6: enabled and cool, channels show latched data
  a_r6_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en_n && !hot) |-> chan_on == latch_q);

  // R7: thermal flag blanks everything
  a_r7_hot_blank: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> chan_on == '0);

  // R7: crossing the set level raises the flag on the next edge
  a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(temp_code) >= 32'(SET_T)) |=> hot);

  // R8: inside the hysteresis band the flag keeps its value
  a_r8_keep_hot: assert property (@(posedge clk) disable iff (!rst_n)
    (hot && 32'(temp_code) > 32'(CLR_T)) |=> hot);
  a_r8_keep_cool: assert property (@(posedge clk) disable iff (!rst_n)
    (!hot && 32'(temp_code) < 32'(SET_T)) |=> !hot);
endmodule

bind led_sink_core led_sink_core_chk #(
  .NCH(NCH), .TEMP_W(TEMP_W), .SET_T(SET_T), .CLR_T(CLR_T)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_in   (ser_in),
  .out_en_n (out_en_n),
  .temp_code(temp_code),
  .shift_q  (shift_q),
  .latch_q  (latch_q),
  .hot      (hot),
  .chan_on  (chan_on)
);

// File: tb/test_led_sink_core.sv
module test_led_sink_core;
  localparam int NCH = 16;
  localparam int TW  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ser_in = 1'b0;
  logic          latch_en = 1'b0;
  logic          out_en_n = 1'b0;
  logic [TW-1:0] temp_code = 8'd25;
  logic          ser_out;
  logic [NCH-1:0] chan_on;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  bit ser_watch = 1'b0;

  always #5 clk = ~clk;

  led_sink_core i_led_sink_core (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
    .out_en_n(out_en_n), .temp_code(temp_code),
    .ser_out(ser_out), .chan_on(chan_on)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Serial model from R1/R2: bits enter at 0, leave from NCH-1.
  logic [NCH-1:0] ser_model;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_model <= '0;
    else        ser_model <= {ser_model[NCH-2:0], ser_in};
  end

  // R2: ser_out checked every cycle away from the edge
  always @(negedge clk) begin
    if (rst_n && ser_watch && !done) check("R2 ser_out", 32'(ser_out), 32'(ser_model[NCH-1]));
  end

  task automatic shift_word(logic [NCH-1:0] w);
    for (int i = NCH - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_in = w[i];
    end
    @(negedge clk);
    ser_in = 1'b0;
  endtask

  // Pulse latch_en between edges so no shift happens while transparent.
  task automatic pulse_latch();
    latch_en = 1'b1;
    #2;
    latch_en = 1'b0;
  endtask

  // Vector: {word, latch, oe_n, temp, expected chan_on}
  localparam int VW = 16 + 1 + 1 + 8 + 16;
  localparam logic [VW-1:0] VEC [10] = '{
    {16'hA5C3, 1'b1, 1'b0, 8'd25,  16'hA5C3},  // R1 R6 basic load
    {16'h1234, 1'b0, 1'b0, 8'd25,  16'hA5C3},  // R4 no latch, hold
    {16'h1234, 1'b1, 1'b1, 8'd25,  16'h0000},  // R5 blanked
    {16'hFFFF, 1'b0, 1'b0, 8'd25,  16'h1234},  // R4 R6 unblanked, held
    {16'h8001, 1'b1, 1'b0, 8'd180, 16'h0000},  // R7 overtemperature
    {16'h0F0F, 1'b0, 1'b0, 8'd160, 16'h0000},  // R8 band keeps hot
    {16'h0F0F, 1'b0, 1'b0, 8'd155, 16'h8001},  // R8 release at CLR_T
    {16'hFFFF, 1'b1, 1'b0, 8'd169, 16'hFFFF},  // R7 SET_T-1 stays cool
    {16'h0000, 1'b0, 1'b0, 8'd170, 16'h0000},  // R7 set exactly at SET_T
    {16'h0000, 1'b0, 1'b0, 8'd100, 16'hFFFF}   // R8 cooled, data back
  };

  initial begin
    // R9: reset state with output enabled
    repeat (3) @(negedge clk);
    check("R9 chan_on in reset", 32'(chan_on), 32'h0);
    check("R9 ser_out in reset", 32'(ser_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R9 chan_on after reset", 32'(chan_on), 32'h0);
    ser_watch = 1'b1;

    for (int k = 0; k < 10; k++) begin
      logic [NCH-1:0] w;
      logic le, oen;
      logic [7:0] t;
      logic [NCH-1:0] ex;
      {w, le, oen, t, ex} = VEC[k];
      shift_word(w);
      out_en_n = oen;
      temp_code = t;
      if (le) pulse_latch();
      @(posedge clk);
      @(negedge clk);
      #1;
      check($sformatf("R6/R7 vector %0d", k), 32'(chan_on), 32'(ex));
    end

    // R3: transparency without a clock edge
    out_en_n = 1'b0;
    temp_code = 8'd25;
    shift_word(16'h00FF);
    @(negedge clk);           // one idle zero shifted: 0x01FE
    #1;
    latch_en = 1'b1;
    #1;
    check("R3 transparent, no edge", 32'(chan_on), 32'h01FE);
    ser_in = 1'b1;
    @(posedge clk);
    #1;
    check("R3 follows shift while high", 32'(chan_on), 32'h03FD);
    @(negedge clk);
    latch_en = 1'b0;
    ser_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R4 holds across shifting", 32'(chan_on), 32'h03FD);

    // R5: output enable acts without a clock
    out_en_n = 1'b1;
    #1;
    check("R5 asynchronous blank", 32'(chan_on), 32'h0);
    out_en_n = 1'b0;
    #1;
    check("R5 release restores", 32'(chan_on), 32'h03FD);

    // R9: reset mid-run clears latches and thermal flag
    temp_code = 8'd200;
    @(posedge clk);
    @(negedge clk);
    #1;
    check("R7 hot before reset", 32'(chan_on), 32'h0);
    temp_code = 8'd160;
    rst_n = 1'b0;
    #1;
    check("R9 ser_out cleared", 32'(ser_out), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    shift_word(16'hAAAA);
    pulse_latch();
    #1;
    check("R9 flag cleared, band stays cool", 32'(chan_on), 32'hAAAA);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule